// File: doc/BRIEF.md
# Chunked-Word I2C Master Controller

This block is a single-master I2C controller that software drives through four 32-bit registers. Software sets a 7-bit target address, a direction bit and a total byte count in one register write. Data then passes through one 32-bit data word that holds up to four bytes. Longer transfers are split into four-byte chunks and a final shorter chunk. The controller pauses after each chunk until software services the data word. During the pause it holds SCL low, so it keeps the bus.

The bus side drives open-drain lines: each output requests that a line be pulled low, and the receive input reads the wired SDA level. SCL has no input, because targets may not stretch the clock. Bit timing comes from a divider field. Each SCL low phase and each SCL high phase lasts that many system clocks. When the target fails to acknowledge, the controller aborts with a STOP and reports a distinct condition code.

Register map (select value): 0 = control, 1 = target, 2 = data, 3 = status. Control holds enable in bit 0, the interrupt enables in bits 5:4 (bit 4 for chunk-done, bit 5 for NAK) and the flags in bits 9:8 (bit 8 chunk-done, bit 9 NAK). Writing 1 to a flag bit clears it. Control bits 31:16 hold the divider. Target holds the address in bits 15:9, the direction in bit 8 (1 = read) and the byte count in bits 7:0. Status holds the condition code in bits 6:4 and the state code in bits 2:0.

Top module: `i2c_chunk_master`

## Requirements
- R1: The first byte after START is the 7-bit target address in bits 7:1 with the direction in bit 0 (0 = write, 1 = read), sent most significant bit first. For a write, the address waits until the data register is written.
- R2: A write to the target register with direction 1 and a non-zero count starts a read. A write to the data register with direction 0 and a non-zero count starts a write. A count of 0 starts nothing and the bus stays idle.
- R3: For a write, each chunk sends min(remaining, 4) bytes from the data word, bits 31:24 first and bits 7:0 last.
- R4: For a read, received bytes fill the data word from bits 31:24 downward. In a chunk shorter than four bytes, the unused low lanes read as zero.
- R5: When reading, the controller ACKs every received byte except the last byte of the whole count. It NACKs that last byte and then issues STOP.
- R6: Exactly one START and one STOP occur per transfer. STOP comes only after the last byte of the full count. Between chunks, SCL is held low and the state code reads 011.
- R7: When the target fails to ACK the address or a data byte, the controller sends no further byte, issues STOP and returns to state code 000. It also sets the NAK flag with condition code 3.
- R8: After each chunk, the chunk-done flag is set. The condition code is 1 when more bytes remain and 2 when the transfer is complete. A waiting transfer resumes only when the flag is clear and software either writes the data register (write) or reads it (read).
- R9: Writing 1 to a flag clears it. The irq output is high exactly when some flag is set and its enable bit is 1.
- R10: Every SCL high phase inside a transfer lasts the divider count in clocks. SDA changes while SCL is high only for START and STOP.
- R11: After reset, both lines are released, irq is 0, status reads 0 and the divider reads its reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 2 | Register select (0 control, 1 target, 2 data, 3 status) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (used for the read handshake) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the selected register |
| irq | output | 1 | Interrupt request: an enabled flag is set |
| sda_in | input | 1 | Sensed level of the wired SDA line |
| scl_drive_low | output | 1 | Pull SCL low when 1, release when 0 |
| sda_drive_low | output | 1 | Pull SDA low when 1, release when 0 |

## Verification
A six-byte write checks that a full chunk and a two-byte tail come out in lane order under one START/STOP pair. A five-byte read separates a full-word chunk from a one-byte tail with zeroed lanes, and its ACK pattern shows the NACK on the final byte only. Two abort runs tell apart a NAK on the address from a NAK partway through a chunk; in each, the bytes that must never reach the bus are checked. A zero count, and a data write made while the flag is still set, check that nothing happens on the bus.

// File: rtl/i2c_cm_pkg.sv
package i2c_cm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_BLO, ST_BHI, ST_HOLD, ST_STOPA, ST_STOPB, ST_STOPC
  } bus_st_t;

  localparam logic [2:0] COND_NONE = 3'd0;
  localparam logic [2:0] COND_MORE = 3'd1;
  localparam logic [2:0] COND_END  = 3'd2;
  localparam logic [2:0] COND_NAK  = 3'd3;

  // bytes in the next chunk
  function automatic logic [2:0] chunk_len(input logic [7:0] rem);
    return (rem >= 8'd4) ? 3'd4 : rem[2:0];
  endfunction

  // place a byte into lane 0 (bits 31:24) .. lane 3 (bits 7:0)
  function automatic logic [31:0] lane_put(input logic [31:0] w,
                                           input logic [7:0] b,
                                           input logic [1:0] lane);
    logic [31:0] r;
    int idx;
    r = w;
    idx = 31 - 8 * int'(lane);
    r[idx -: 8] = b;
    return r;
  endfunction

  function automatic logic [2:0] state_code(input bus_st_t st, input logic addr_phase);
    case (st)
      ST_IDLE:                    return 3'b000;
      ST_HOLD:                    return 3'b011;
      ST_STOPA, ST_STOPB, ST_STOPC: return 3'b100;
      default:                    return addr_phase ? 3'b001 : 3'b010;
    endcase
  endfunction

endpackage

// File: rtl/i2c_cm_tick.sv
module i2c_cm_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] last;

  assign last = (div == '0) ? '0 : div - 1'b1;
  assign tick = run && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2c_cm_engine.sv
module i2c_cm_engine
  import i2c_cm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        start,
  input  logic        resume,
  input  logic [6:0]  tgt,
  input  logic        dir,
  input  logic [7:0]  count,
  input  logic [31:0] wdata,
  input  logic        sda_in,
  output logic        run,
  output logic        scl_low,
  output logic        sda_low,
  output logic [31:0] rx_word,
  output logic        rx_valid,
  output logic        ev_chunk,
  output logic        ev_last,
  output logic        ev_nak,
  output logic [2:0]  code
);
  bus_st_t     st;
  logic [7:0]  rem;
  logic [2:0]  cleft;
  logic [1:0]  lane;
  logic [3:0]  bitn;
  logic [7:0]  sh;
  logic [31:0] word;
  logic        is_addr, rd;

  // named internal events
  logic tx_byte, ack_slot, byte_end, nak_c, data_c, last_c, chunk_c;
  assign tx_byte  = is_addr || !rd;
  assign ack_slot = (bitn == 4'd8);
  assign byte_end = tick && (st == ST_BHI) && ack_slot;
  assign nak_c    = byte_end && tx_byte && sda_in;
  assign data_c   = byte_end && !is_addr && !nak_c;
  assign last_c   = data_c && (rem == 8'd1);
  assign chunk_c  = data_c && (rem != 8'd1) && (cleft == 3'd1);

  assign run     = (st != ST_IDLE) && (st != ST_HOLD);
  assign scl_low = (st == ST_BLO) || (st == ST_HOLD) || (st == ST_STOPA);
  assign code    = state_code(st, is_addr);

  always_comb begin
    case (st)
      ST_START, ST_STOPA, ST_STOPB: sda_low = 1'b1;
      ST_BLO, ST_BHI:
        sda_low = ack_slot ? (!tx_byte && rem != 8'd1) : (tx_byte && !sh[7]);
      default: sda_low = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; rem <= '0; cleft <= '0; lane <= '0; bitn <= '0;
      sh <= '0; word <= '0; is_addr <= 1'b0; rd <= 1'b0; rx_word <= '0;
      rx_valid <= 1'b0; ev_chunk <= 1'b0; ev_last <= 1'b0; ev_nak <= 1'b0;
    end else begin
      rx_valid <= data_c && rd && (last_c || chunk_c);
      ev_chunk <= chunk_c;
      ev_last  <= last_c;
      ev_nak   <= nak_c;
      case (st)
        ST_IDLE: if (start) begin
          sh <= {tgt, dir}; rd <= dir; rem <= count; word <= wdata;
          is_addr <= 1'b1; bitn <= '0; st <= ST_START;
        end
        ST_START: if (tick) st <= ST_BLO;
        ST_BLO:   if (tick) st <= ST_BHI;
        ST_BHI: if (tick) begin
          if (!ack_slot) begin
            sh <= {sh[6:0], sda_in};
            bitn <= bitn + 1'b1;
            st <= ST_BLO;
          end else begin
            bitn <= '0;
            if (nak_c) st <= ST_STOPA;
            else if (is_addr) begin
              is_addr <= 1'b0; cleft <= chunk_len(rem); lane <= '0;
              rx_word <= '0; sh <= word[31:24]; word <= word << 8;
              st <= ST_BLO;
            end else begin
              rem <= rem - 1'b1;
              lane <= lane + 1'b1;
              if (rd) rx_word <= lane_put(rx_word, sh, lane);
              if (rem == 8'd1) st <= ST_STOPA;
              else if (cleft == 3'd1) st <= ST_HOLD;
              else begin
                cleft <= cleft - 1'b1; sh <= word[31:24]; word <= word << 8;
                st <= ST_BLO;
              end
            end
          end
        end
        ST_HOLD: if (resume) begin
          cleft <= chunk_len(rem); lane <= '0;
          if (rd) rx_word <= '0;
          else begin sh <= wdata[31:24]; word <= wdata << 8; end
          st <= ST_BLO;
        end
        ST_STOPA: if (tick) st <= ST_STOPB;
        ST_STOPB: if (tick) st <= ST_STOPC;
        ST_STOPC: if (tick) st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  // R7: a missing acknowledge leads straight into the STOP sequence
  assert_nak_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    nak_c |=> (st == ST_STOPA));
  // R5: the final byte of the count is followed by STOP
  assert_last_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    last_c |=> (st == ST_STOPA));
  // R6: a chunk boundary parks the bus with SCL low instead of stopping
  assert_chunk_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_c |=> (st == ST_HOLD && scl_low));
  // R3: a data byte never completes with nothing left to send
  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    data_c |-> (rem != 8'd0));
  // R3: chunk size stays within one data word
  assert_chunk_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BLO && !is_addr) |-> (cleft != 3'd0 && cleft <= 3'd4));
  // R10: SDA steady while SCL is high during a bit
  assert_sda_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BHI && $past(st) == ST_BHI) |-> $stable(sda_low));
endmodule

// File: rtl/i2c_chunk_master.sv
module i2c_chunk_master
  import i2c_cm_pkg::*;
#(
  parameter int DIV_W   = 16,   // divider width, at most 16 (control bits 31:16)
  parameter int DIV_RST = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  reg_sel,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  input  logic        sda_in,
  output logic        scl_drive_low,
  output logic        sda_drive_low
);
  localparam logic [1:0] SEL_CTRL = 2'd0, SEL_TGT = 2'd1, SEL_DATA = 2'd2, SEL_STAT = 2'd3;

  logic             en;
  logic [1:0]       ie;
  logic [DIV_W-1:0] div;
  logic [6:0]       tgt;
  logic             dir;
  logic [7:0]       cnt;
  logic [31:0]      data_reg;
  logic             f_done, f_nak;
  logic [2:0]       cond;

  logic        tick, run, rx_valid, ev_chunk, ev_last, ev_nak;
  logic [31:0] rx_word;
  logic [2:0]  code;

  // decoded access events
  logic wr_ctrl, wr_tgt, wr_data, rd_data, idle, hold, go, resume, done_ev;
  assign wr_ctrl = reg_wr && reg_sel == SEL_CTRL;
  assign wr_tgt  = reg_wr && reg_sel == SEL_TGT;
  assign wr_data = reg_wr && reg_sel == SEL_DATA;
  assign rd_data = reg_rd && reg_sel == SEL_DATA;
  assign idle    = (code == 3'b000);
  assign hold    = (code == 3'b011);
  assign done_ev = ev_chunk || ev_last;
  assign go      = en && idle &&
                   ((wr_tgt && reg_wdata[8] && reg_wdata[7:0] != 8'd0) ||
                    (wr_data && !dir && cnt != 8'd0));
  assign resume  = hold && !f_done && ((wr_data && !dir) || (rd_data && dir));

  i2c_cm_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .div(div), .tick(tick));

  i2c_cm_engine u_eng (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(go), .resume(resume),
    .tgt(wr_tgt ? reg_wdata[15:9] : tgt), .dir(wr_tgt ? reg_wdata[8] : dir),
    .count(wr_tgt ? reg_wdata[7:0] : cnt), .wdata(reg_wdata), .sda_in(sda_in),
    .run(run), .scl_low(scl_drive_low), .sda_low(sda_drive_low),
    .rx_word(rx_word), .rx_valid(rx_valid), .ev_chunk(ev_chunk),
    .ev_last(ev_last), .ev_nak(ev_nak), .code(code));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; ie <= '0; div <= DIV_W'(DIV_RST);
      tgt <= '0; dir <= 1'b0; cnt <= '0; data_reg <= '0;
      f_done <= 1'b0; f_nak <= 1'b0; cond <= COND_NONE;
    end else begin
      if (wr_ctrl) begin
        en  <= reg_wdata[0];
        ie  <= reg_wdata[5:4];
        div <= reg_wdata[16 +: DIV_W];
      end
      if (wr_tgt && idle) begin
        tgt <= reg_wdata[15:9]; dir <= reg_wdata[8]; cnt <= reg_wdata[7:0];
      end
      if (rx_valid)     data_reg <= rx_word;
      else if (wr_data) data_reg <= reg_wdata;
      if (done_ev)                      f_done <= 1'b1;
      else if (wr_ctrl && reg_wdata[8]) f_done <= 1'b0;
      if (ev_nak)                       f_nak <= 1'b1;
      else if (wr_ctrl && reg_wdata[9]) f_nak <= 1'b0;
      if (ev_nak)        cond <= COND_NAK;
      else if (ev_last)  cond <= COND_END;
      else if (ev_chunk) cond <= COND_MORE;
      else if (go)       cond <= COND_NONE;
    end
  end

  assign irq = |({f_nak, f_done} & ie);

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_CTRL: begin
        reg_rdata[0] = en; reg_rdata[5:4] = ie;
        reg_rdata[8] = f_done; reg_rdata[9] = f_nak;
        reg_rdata[16 +: DIV_W] = div;
      end
      SEL_TGT:  reg_rdata[15:0] = {tgt, dir, cnt};
      SEL_DATA: reg_rdata = data_data_sel(data_reg);
      default:  begin reg_rdata[6:4] = cond; reg_rdata[2:0] = code; end
    endcase
  end

  function automatic logic [31:0] data_data_sel(input logic [31:0] d);
    return d;
  endfunction

  // R9: a write-one clear removes the done flag unless a new chunk ends at once
  assert_w1c_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && reg_wdata[8] && !done_ev) |=> !f_done);
  // R8: a flagged chunk end leaves the flag set on the next cycle
  assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev |=> f_done);
endmodule

// File: tb/tb_i2c_chunk_master.sv
module tb_i2c_chunk_master;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;
  localparam logic [31:0] CBASE = (32'(DIV) << 16) | 32'h11;
  localparam logic [31:0] CLR   = 32'h300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] reg_sel = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  wire [31:0] reg_rdata;
  wire irq, scl_drive_low, sda_drive_low;
  logic s_drive = 1'b0;
  wire scl_line = !scl_drive_low;
  wire sda_line = !(sda_drive_low || s_drive);

  i2c_chunk_master dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .sda_in(sda_line),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit fin = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // behavioural target and bus monitor, evaluated every clock
  logic [7:0] got[$];
  logic [7:0] rdsrc[$];
  logic       ackq[$];
  int starts = 0, stops = 0, nak_at = -1;
  bit in_x = 0, first = 0, rdm = 0, go_tx = 0, ps = 1, psd = 1;
  int bits = 0, bidx = 0, rise_cyc = -1, hi_meas = 0, hi_bad = 0;
  logic [7:0] acc = '0, txb = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (ps && scl_line && psd && !sda_line) begin
        starts++; in_x = 1; bits = 0; first = 1; bidx = 0; rdm = 0;
        go_tx = 0; s_drive = 0; rise_cyc = -1;
      end else if (ps && scl_line && !psd && sda_line) begin
        stops++; in_x = 0; s_drive = 0;
      end else if (in_x && !ps && scl_line) begin
        rise_cyc = cyc;
        if (bits < 8) begin
          if (!(rdm && !first)) acc = {acc[6:0], sda_line};
        end else if (rdm && !first) begin
          ackq.push_back(sda_line); go_tx = !sda_line;
        end
        bits++;
      end else if (in_x && ps && !scl_line) begin
        if (rise_cyc >= 0) begin
          hi_meas++;
          if (cyc - rise_cyc != DIV) hi_bad++;
        end
        if (bits == 8) begin
          if (rdm && !first) s_drive = 0;
          else begin
            got.push_back(acc);
            if (first) rdm = acc[0];
            s_drive = (bidx != nak_at);
            go_tx = (bidx != nak_at);
            bidx++;
          end
        end else if (bits == 9) begin
          bits = 0; first = 0; s_drive = 0;
          if (rdm && go_tx) begin
            txb = (rdsrc.size() > 0) ? rdsrc.pop_front() : 8'hFF;
            s_drive = !txb[7];
          end
        end else if (rdm && !first && bits > 0 && bits < 8) begin
          s_drive = !txb[7 - bits];
        end
      end
      ps = scl_line; psd = sda_line;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); reg_sel = s; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rdr(input logic [1:0] s, output logic [31:0] d);
    @(negedge clk); reg_sel = s; reg_rd = 1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic wait_flag();
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      rdr(2'd0, v);
      if (v[9:8] != 2'b00) return;
    end
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      rdr(2'd3, v);
      if (v[2:0] == 3'b000) return;
    end
  endtask

  task automatic chk_got(input string req, input logic [7:0] e[$]);
    chk(got.size() == e.size(), req, got.size(), e.size());
    for (int i = 0; i < e.size() && i < got.size(); i++)
      chk(got[i] == e[i], req, got[i], e[i]);
    got.delete();
  endtask

  initial begin
    logic [31:0] v;
    int s0;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk(scl_drive_low == 0 && sda_drive_low == 0, "R11", {scl_drive_low, sda_drive_low}, 0);
    chk(irq == 0, "R11", irq, 0);
    rdr(2'd3, v); chk(v == 0, "R11", v, 0);
    rst_n = 1;
    rdr(2'd0, v); chk(v[31:16] == DIV, "R11", v[31:16], DIV);

    wr(2'd0, CBASE);
    // six-byte write to 0x2A: address alone must not start the bus (R1)
    wr(2'd1, (32'h2A << 9) | 32'd6);
    repeat (20) @(negedge clk);
    chk(starts == 0, "R1", starts, 0);
    wr(2'd2, 32'h11223344);
    wait_flag();
    rdr(2'd3, v);
    chk(v[6:4] == 1, "R8", v[6:4], 1);
    chk(v[2:0] == 3'b011, "R6", v[2:0], 3);
    chk(scl_drive_low == 1, "R6", scl_drive_low, 1);
    chk(irq == 1, "R9", irq, 1);
    chk_got("R3", '{8'h54, 8'h11, 8'h22, 8'h33, 8'h44});
    // resume blocked while flag still set (R8)
    wr(2'd2, 32'h55667788);
    repeat (200) @(negedge clk);
    chk(got.size() == 0, "R8", got.size(), 0);
    wr(2'd0, CBASE | CLR);
    chk(irq == 0, "R9", irq, 0);
    rdr(2'd0, v); chk(v[8] == 0, "R9", v[8], 0);
    wr(2'd2, 32'h55667788);
    wait_flag();
    rdr(2'd3, v); chk(v[6:4] == 2, "R8", v[6:4], 2);
    wait_idle();
    chk_got("R3", '{8'h55, 8'h66});
    chk(starts == 1 && stops == 1, "R6", {starts[15:0], stops[15:0]}, 32'h10001);

    // five-byte read from 0x31
    wr(2'd0, CBASE | CLR);
    rdsrc = '{8'hA1, 8'hB2, 8'hC3, 8'hD4, 8'hE5};
    wr(2'd1, (32'h31 << 9) | 32'h100 | 32'd5);
    wait_flag();
    rdr(2'd3, v); chk(v[6:4] == 1, "R8", v[6:4], 1);
    chk(stops == 1, "R6", stops, 1);
    wr(2'd0, CBASE | CLR);
    rdr(2'd2, v); chk(v == 32'hA1B2C3D4, "R4", v, 32'hA1B2C3D4);
    wait_flag();
    rdr(2'd3, v); chk(v[6:4] == 2, "R8", v[6:4], 2);
    wr(2'd0, CBASE | CLR);
    rdr(2'd2, v); chk(v == 32'hE5000000, "R4", v, 32'hE5000000);
    wait_idle();
    chk_got("R1", '{8'h63});
    chk(ackq.size() == 5, "R5", ackq.size(), 5);
    for (int i = 0; i < ackq.size(); i++)
      chk(ackq[i] == (i == 4), "R5", ackq[i], (i == 4));
    chk(starts == 2 && stops == 2, "R6", {starts[15:0], stops[15:0]}, 32'h20002);

    // NAK on the address
    nak_at = 0;
    wr(2'd1, (32'h10 << 9) | 32'd3);
    wr(2'd2, 32'hCAFEF00D);
    wait_flag();
    rdr(2'd3, v); chk(v[6:4] == 3, "R7", v[6:4], 3);
    rdr(2'd0, v); chk(v[9:8] == 2'b10, "R7", v[9:8], 2);
    chk(irq == 0, "R9", irq, 0);
    wait_idle();
    rdr(2'd3, v); chk(v[2:0] == 0, "R7", v[2:0], 0);
    chk(stops == 3, "R7", stops, 3);
    chk_got("R7", '{8'h20});
    wr(2'd0, CBASE | 32'h20);
    chk(irq == 1, "R9", irq, 1);

    // NAK on the second data byte: later bytes never appear
    wr(2'd0, CBASE | CLR);
    nak_at = 2;
    wr(2'd1, (32'h22 << 9) | 32'd4);
    wr(2'd2, 32'hDEADBEEF);
    wait_flag();
    wait_idle();
    repeat (100) @(negedge clk);
    chk_got("R7", '{8'h44, 8'hDE, 8'hAD});
    chk(stops == 4, "R7", stops, 4);
    nak_at = -1;

    // zero count starts nothing
    wr(2'd0, CBASE | CLR);
    s0 = starts;
    wr(2'd1, (32'h31 << 9) | 32'h100);
    repeat (100) @(negedge clk);
    chk(starts == s0, "R2", starts, s0);
    rdr(2'd3, v); chk(v[2:0] == 0, "R2", v[2:0], 0);

    // SCL high-phase length
    chk(hi_meas > 50, "R10", hi_meas, 51);
    chk(hi_bad == 0, "R10", hi_bad, 0);

    fin = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule